// File: doc/BRIEF.md
# Predicated Output Selection Network

This block is the output stage of an array of processing elements. It makes two results. The first-stage result is combinational. The second-stage result is registered so that it lines up with the next pipeline stage. Each result comes from its own two-input multiplexer. The two data inputs of each multiplexer are wired to fixed processing-element results: one is the "then" input and the other is the "else" input.

Each output has two configuration bits: a mode bit and a static select bit. When the mode bit is clear, the static select bit picks the input, and the block works as a plain configured output route. When the mode bit is set, the multiplexer follows a compare flag produced at run time by a fixed processing element. This lets an if-then-else be converted into straight-line code. Both branches are computed side by side, and the compare outcome (for example a sign test) chooses which value leaves the array. No branch is needed.

Top module: `pred_out_net`

## Requirements
- R1: With the stage-1 mode bit clear, `s1_res_o` shows the "then" element result when `s1_sel_i` is 1 and the "else" element result when it is 0, in the same cycle.
- R2: With the stage-1 mode bit set, `s1_res_o` shows the "then" element result when the stage-1 compare flag is 1 and the "else" result when it is 0. `s1_sel_i` has no effect.
- R3: With a mode bit clear, the compare flag for that output has no effect on the output.
- R4: On a rising clock edge with `adv_i` high and the stage-2 mode bit clear, `s2_res_o` takes the stage-2 "then" result if `s2_sel_i` is 1, or the "else" result if it is 0, using the inputs present at that edge.
- R5: On a rising clock edge with `adv_i` low, `s2_res_o` keeps its value.
- R6: While `rst_ni` is low, `s2_res_o` is zero.
- R7: On a rising edge with `adv_i` high and the stage-2 mode bit set, `s2_res_o` takes the stage-2 "then" result if the stage-2 compare flag is 1, or the "else" result if it is 0. `s2_sel_i` has no effect.
- R8: With the default parameters, the fixed connections are as follows. Stage 1 takes "then" from element 0, "else" from element 1, and its flag from element 2. Stage 2 takes "then" from element 4, "else" from element 5, and its flag from element 6. Element k occupies bits k*32 to k*32+31 of `pe_res_i` and bit k of `pe_flag_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Pipeline advance, the clock enable of the stage-2 register |
| pe_res_i | input | NUM_PE*DATA_W (256) | Concatenated element results, element k at slice k |
| pe_flag_i | input | NUM_PE (8) | Element compare flags, element k at bit k |
| s1_pred_i | input | 1 | Stage-1 mode: 1 = predicated, 0 = static |
| s1_sel_i | input | 1 | Stage-1 static select: 1 = then, 0 = else |
| s2_pred_i | input | 1 | Stage-2 mode: 1 = predicated, 0 = static |
| s2_sel_i | input | 1 | Stage-2 static select: 1 = then, 0 = else |
| s1_res_o | output | DATA_W (32) | First-stage result (combinational) |
| s2_res_o | output | DATA_W (32) | Second-stage result (registered) |

## Verification
The bench drives the static select and the compare flag against each other. A design that took its select from the wrong source would pass a value that the requirement forbids. Each element carries a distinct value, so a multiplexer wired to the wrong element, or one output reading the other output's flag, shows up as a wrong word. The bench also tests stall and reset cycles. A stage-2 register that ignored its enable, or that loaded one cycle late, would differ from the reference model on the cycle after `adv_i` changes.

// File: rtl/pred_out_pkg.sv
package pred_out_pkg;

  // Per-output configuration: mode and static select
  typedef struct packed {
    logic pred;  // 1: compare flag steers the mux
    logic sel;   // static select, 1 = then input
  } ocfg_t;

  // Resolve the effective select of one output mux
  function automatic logic eff_sel(input ocfg_t cfg, input logic flag);
    return cfg.pred ? flag : cfg.sel;
  endfunction

endpackage

// File: rtl/pred_out_mux.sv
module pred_out_mux
  import pred_out_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_PE   = 8,
  parameter int THEN_IDX = 0,
  parameter int ELSE_IDX = 1,
  parameter int FLAG_IDX = 2
) (
  input  logic [NUM_PE*DATA_W-1:0] pe_res_i,
  input  logic [NUM_PE-1:0]        pe_flag_i,
  input  ocfg_t                    cfg_i,
  output logic [DATA_W-1:0]        res_o
);

  logic [DATA_W-1:0] then_val;
  logic [DATA_W-1:0] else_val;
  logic              sel;

  // Fixed taps on the element result bus
  assign then_val = pe_res_i[THEN_IDX*DATA_W +: DATA_W];
  assign else_val = pe_res_i[ELSE_IDX*DATA_W +: DATA_W];

  always_comb begin
    sel   = eff_sel(cfg_i, pe_flag_i[FLAG_IDX]);
    res_o = sel ? then_val : else_val;
  end

endmodule

// File: rtl/pred_out_reg.sv
module pred_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_nxt;
  end

endmodule

// File: rtl/pred_out_net.sv
module pred_out_net
  import pred_out_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_PE  = 8,
  parameter int S1_THEN = 0,
  parameter int S1_ELSE = 1,
  parameter int S1_FLAG = 2,
  parameter int S2_THEN = 4,
  parameter int S2_ELSE = 5,
  parameter int S2_FLAG = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic [NUM_PE*DATA_W-1:0] pe_res_i,
  input  logic [NUM_PE-1:0]        pe_flag_i,
  input  logic                     s1_pred_i,
  input  logic                     s1_sel_i,
  input  logic                     s2_pred_i,
  input  logic                     s2_sel_i,
  output logic [DATA_W-1:0]        s1_res_o,
  output logic [DATA_W-1:0]        s2_res_o
);

  localparam int BUS_W = NUM_PE * DATA_W;

  ocfg_t             s1_cfg;
  ocfg_t             s2_cfg;
  logic [DATA_W-1:0] s2_pre;

  assign s1_cfg = '{pred: s1_pred_i, sel: s1_sel_i};
  assign s2_cfg = '{pred: s2_pred_i, sel: s2_sel_i};

  // First-stage output: combinational
  pred_out_mux #(
    .DATA_W(DATA_W), .NUM_PE(NUM_PE),
    .THEN_IDX(S1_THEN), .ELSE_IDX(S1_ELSE), .FLAG_IDX(S1_FLAG)
  ) u_s1_mux (
    .pe_res_i (pe_res_i),
    .pe_flag_i(pe_flag_i),
    .cfg_i    (s1_cfg),
    .res_o    (s1_res_o)
  );

  // Second-stage output: selected, then registered
  pred_out_mux #(
    .DATA_W(DATA_W), .NUM_PE(NUM_PE),
    .THEN_IDX(S2_THEN), .ELSE_IDX(S2_ELSE), .FLAG_IDX(S2_FLAG)
  ) u_s2_mux (
    .pe_res_i (pe_res_i),
    .pe_flag_i(pe_flag_i),
    .cfg_i    (s2_cfg),
    .res_o    (s2_pre)
  );

  pred_out_reg #(.DATA_W(DATA_W)) u_s2_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (adv_i),
    .d_i   (s2_pre),
    .q_o   (s2_res_o)
  );

  // Checks on the port behaviour
  logic [DATA_W-1:0] s1_then_w, s1_else_w, s2_then_w, s2_else_w;
  assign s1_then_w = pe_res_i[S1_THEN*DATA_W +: DATA_W];
  assign s1_else_w = pe_res_i[S1_ELSE*DATA_W +: DATA_W];
  assign s2_then_w = pe_res_i[S2_THEN*DATA_W +: DATA_W];
  assign s2_else_w = pe_res_i[S2_ELSE*DATA_W +: DATA_W];

  AST_S1_STATIC_THEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_pred_i && s1_sel_i) |-> (s1_res_o == s1_then_w)); // R1
  AST_S1_PRED_ELSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_pred_i && !pe_flag_i[S1_FLAG]) |-> (s1_res_o == s1_else_w)); // R2
  AST_S2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(s2_res_o)); // R5
  AST_S2_LOAD_STATIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !s2_pred_i && !s2_sel_i) |=> (s2_res_o == $past(s2_else_w))); // R4
  AST_S2_LOAD_PRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && s2_pred_i && pe_flag_i[S2_FLAG]) |=> (s2_res_o == $past(s2_then_w))); // R7
  AST_RST_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (s2_res_o == '0)); // R6

  logic unused_w;
  assign unused_w = ^{BUS_W[0]};

endmodule

// File: tb/tb_pred_out_net.sv
module tb_pred_out_net;

  localparam int DW = 32;
  localparam int NP = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             adv_i;
  logic [NP*DW-1:0] pe_res_i;
  logic [NP-1:0]    pe_flag_i;
  logic             s1_pred_i, s1_sel_i, s2_pred_i, s2_sel_i;
  logic [DW-1:0]    s1_res_o, s2_res_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [DW-1:0] exp_s2;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  pred_out_net dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i),
    .pe_res_i(pe_res_i), .pe_flag_i(pe_flag_i),
    .s1_pred_i(s1_pred_i), .s1_sel_i(s1_sel_i),
    .s2_pred_i(s2_pred_i), .s2_sel_i(s2_sel_i),
    .s1_res_o(s1_res_o), .s2_res_o(s2_res_o)
  );

  function automatic logic [DW-1:0] pe(input int k);
    return pe_res_i[k*DW +: DW];
  endfunction

  // Reference: stage 1 then=0 else=1 flag=2; stage 2 then=4 else=5 flag=6 (R8)
  function automatic logic [DW-1:0] ref_s1();
    logic s;
    s = s1_pred_i ? pe_flag_i[2] : s1_sel_i;
    return s ? pe(0) : pe(1);
  endfunction

  function automatic logic [DW-1:0] ref_s2();
    logic s;
    s = s2_pred_i ? pe_flag_i[6] : s2_sel_i;
    return s ? pe(4) : pe(5);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_distinct();
    for (int k = 0; k < NP; k++) pe_res_i[k*DW +: DW] = 32'hA000_0000 + k * 32'h0101_0101;
  endtask

  task automatic fill_random();
    for (int k = 0; k < NP; k++) pe_res_i[k*DW +: DW] = $urandom;
    pe_flag_i = 8'($urandom);
  endtask

  // One cycle: inputs already driven at negedge; check s1, clock, check s2
  task automatic cycle(input string s1tag);
    string s2tag;
    logic [DW-1:0] nxt;
    #1;
    chk(s1tag, s1_res_o, ref_s1());
    if (!adv_i) s2tag = "R5"; else if (s2_pred_i) s2tag = "R7"; else s2tag = "R4";
    nxt = adv_i ? ref_s2() : exp_s2;
    @(posedge clk_i);
    exp_s2 = nxt;
    #1;
    chk(s2tag, s2_res_o, exp_s2);
    @(negedge clk_i);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; adv_i = 1'b1; pe_flag_i = '0;
    s1_pred_i = 0; s1_sel_i = 0; s2_pred_i = 0; s2_sel_i = 1;
    fill_distinct();
    exp_s2 = '0;
    repeat (3) @(posedge clk_i);
    #1 chk("R6", s2_res_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8 / R1 / R4: distinct values show the fixed taps
    s1_sel_i = 1; s2_sel_i = 1; cycle("R1");
    chk("R8", s1_res_o, 32'hA000_0000);
    chk("R8", s2_res_o, 32'hA404_0404);
    s1_sel_i = 0; s2_sel_i = 0; cycle("R1");
    chk("R8", s1_res_o, 32'hA101_0101);
    chk("R8", s2_res_o, 32'hA505_0505);

    // R3: flags toggled in static mode have no effect
    s1_sel_i = 1; s2_sel_i = 0; pe_flag_i = 8'hFF; cycle("R3");
    pe_flag_i = 8'h00; cycle("R3");

    // R2 / R7: predicated, static select set opposite to flag
    s1_pred_i = 1; s2_pred_i = 1;
    pe_flag_i = 8'h04; s1_sel_i = 0; s2_sel_i = 1; cycle("R2");
    chk("R7", s2_res_o, 32'hA505_0505);
    pe_flag_i = 8'h40; s1_sel_i = 1; s2_sel_i = 0; cycle("R2");
    chk("R7", s2_res_o, 32'hA404_0404);

    // R5: stall, inputs change but stage 2 holds
    adv_i = 0; pe_flag_i = 8'h00; fill_random(); cycle("R2");
    fill_random(); cycle("R2");
    adv_i = 1; cycle("R2");

    // Random mix of modes, selects, flags and stalls
    for (int i = 0; i < 300; i++) begin
      fill_random();
      s1_pred_i = 1'($urandom); s1_sel_i = 1'($urandom);
      s2_pred_i = 1'($urandom); s2_sel_i = 1'($urandom);
      adv_i = ($urandom % 4) != 0;
      cycle(s1_pred_i ? "R2" : "R1");
    end

    // R6: reset mid-run clears stage 2
    rst_ni = 1'b0; #1;
    chk("R6", s2_res_o, '0);
    exp_s2 = '0;
    @(negedge clk_i); rst_ni = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule